// File: doc/BRIEF.md
# Watchdog Timer with Programmable Prescaler

This peripheral guards a processor subsystem against runaway software. It sits on a narrow special-function-register bus and exposes two byte-wide registers. The control register holds an enable, a clear strobe and a 3-bit divider select. The status register holds a sticky flag that records a watchdog-caused reset. Once software enables it, a prescaler divides the clock by 8, 16, 32 and so on up to 1024. Each prescaled tick advances a wide up-counter.

If software fails to write the clear strobe before the counter wraps from all-ones to zero, the block raises a reset request for a fixed number of cycles. On the same edge it sets the cause flag and drops its own enable, exactly as any reset would. The flag survives this self-inflicted reset, so software can read it after restarting. Only the external reset input (power-on or pin reset) or a software write of 0 clears the flag. The external reset also forces the enable and the select to zero.

Top module: `sfr_watchdog`

## Requirements
- R1: After the external reset, both registers read 0x00 and the reset request is low.
- R2: The control register is at address 0x9F. Bit 7 is the enable and bits 2:0 are the divider select, and both read back as written. Bit 5 is the clear strobe and reads 0. Bits 6, 4 and 3 read 0. Any other address reads 0x00.
- R3: With select value s, the reset request first rises exactly 2^CNT_W × (8 × 2^s) clock edges after the edge that captured the enabling write, and is low before then.
- R4: Writing the control register with bit 5 set zeroes the counter and the prescaler on that edge, so a full timeout period starts again from that edge.
- R5: Each overflow drives the reset request high for exactly PULSE_LEN (4) consecutive cycles.
- R6: On overflow the enable bit drops to 0 and the select is kept. No further reset request follows until software enables the block again.
- R7: The status register is at address 0xBE and bit 0 is the cause flag. The flag sets on overflow and survives the watchdog reset. A write with bit 0 = 0 clears it, a write with bit 0 = 1 does not set it, and the external reset clears it.
- R8: While the enable is 0, the counter and the prescaler hold their values. Counting resumes from the held position when the block is enabled again.
- R9: A change of select while the block is running takes effect at the next prescaler tick and leaves the counter value intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the prescaler divides |
| rst_n | input | 1 | Synchronous active-low external/power-on reset |
| sfr_addr | input | 8 | Register bus address, also selects the read data |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Write strobe, captured on the rising clock edge |
| sfr_rdata | output | 8 | Combinational read data for the addressed register |
| wdt_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong count in the prescaler or the counter shows only as a reset request that arrives at the wrong edge. So every timeout scenario counts edges from the enabling write and demands the rising edge on exactly the predicted cycle, and any early pulse counts as an error. A stuck enable or a lost select would stay hidden until the next overflow, so they are read back through the control register right after each pulse. Damage to the cause flag is visible immediately on a status read.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the watchdog peripheral.
// Assumes an 8-bit address / 8-bit data register bus.
package wdt_pkg;
    localparam int SFR_AW    = 8;
    localparam int SFR_DW    = 8;
    localparam int EN_BIT    = 7;   // control: enable
    localparam int CLR_BIT   = 5;   // control: clear strobe
    localparam int CAUSE_BIT = 0;   // status: watchdog-caused reset flag
    localparam logic [SFR_AW-1:0] CTRL_ADDR_DEF = 8'h9F;
    localparam logic [SFR_AW-1:0] STAT_ADDR_DEF = 8'hBE;

    // one register-bus write as seen by the decoder
    typedef struct packed {
        logic              we;
        logic [SFR_AW-1:0] addr;
        logic [SFR_DW-1:0] wdata;
    } sfr_wr_t;
endpackage

// File: rtl/wdt_sfr_regs.sv
`timescale 1ns/1ps
// Module: wdt_sfr_regs
// Decodes the register bus and holds the enable, the divider select and the
// sticky cause flag. It produces a one-cycle clear strobe.
// Assumes: rst_n is the external reset only. The watchdog's own reset takes
// effect through ovf, so the cause flag survives it.
module wdt_sfr_regs
    import wdt_pkg::*;
#(
    parameter int                SEL_W     = 3,
    parameter logic [SFR_AW-1:0] CTRL_ADDR = CTRL_ADDR_DEF,
    parameter logic [SFR_AW-1:0] STAT_ADDR = STAT_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sfr_wr_t           wr,
    input  logic [SFR_AW-1:0] rd_addr,
    input  logic              ovf,
    output logic              en,
    output logic [SEL_W-1:0]  sel,
    output logic              clr,
    output logic [SFR_DW-1:0] rdata
);
    logic ctrl_wr, stat_wr;
    logic flag_q;

    assign ctrl_wr = wr.we && (wr.addr == CTRL_ADDR);
    assign stat_wr = wr.we && (wr.addr == STAT_ADDR);
    assign clr     = ctrl_wr && wr.wdata[CLR_BIT];

    // enable and select; overflow forces the enable off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            sel <= '0;
        end else begin
            if (ctrl_wr) begin
                en  <= wr.wdata[EN_BIT];
                sel <= wr.wdata[SEL_W-1:0];
            end
            if (ovf) en <= 1'b0;
        end
    end

    // sticky cause flag: set on overflow, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                               flag_q <= 1'b0;
        else if (ovf)                             flag_q <= 1'b1;
        else if (stat_wr && !wr.wdata[CAUSE_BIT]) flag_q <= 1'b0;
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (rd_addr == CTRL_ADDR) begin
            rdata[EN_BIT]    = en;
            rdata[SEL_W-1:0] = sel;
        end else if (rd_addr == STAT_ADDR) begin
            rdata[CAUSE_BIT] = flag_q;
        end
    end

    // R6
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !en);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
// Module: wdt_prescaler
// Free-running divider that emits a one-cycle tick every 2^(BASE_LOG2+sel)
// enabled cycles. The tick fires when the low bits of the divider are all
// ones. A select change therefore applies at the next matching position and
// needs no reload.
// Assumes: clr has priority and zeroes the divider; nothing advances while
// the enable is 0.
module wdt_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             tick
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int PRE_W   = BASE_LOG2 + MAX_SEL;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic [SEL_W-1:0] shamt;

    // mask of the low divider bits that select the tick position
    always_comb begin
        shamt = SEL_W'(MAX_SEL) - sel;
        mask  = {PRE_W{1'b1}} >> shamt;
    end

    assign tick = en && ((pre & mask) == mask);

    // divider register
    always_ff @(posedge clk) begin
        if (!rst_n)  pre <= '0;
        else if (clr) pre <= '0;
        else if (en)  pre <= pre + 1'b1;
    end

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(pre));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
// Module: wdt_counter
// Timeout counter that advances on each prescaler tick and flags the wrap
// from all-ones to zero.
// Assumes: a clear in the same cycle as a wrapping tick wins, so no
// overflow is reported.
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic ovf
);
    logic [CNT_W-1:0] cnt;

    assign ovf = tick && !clr && (&cnt);

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));
endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/1ps
// Module: wdt_rst_pulse
// Stretches the single-cycle overflow into a fixed-length reset request.
// Assumes: no new overflow arrives during a pulse, because the enable drops
// when the pulse starts.
module wdt_rst_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    output logic rst_req
);
    localparam int REM_W = $clog2(PULSE_LEN + 1);

    logic [REM_W-1:0] rem;

    // remaining pulse cycles
    always_ff @(posedge clk) begin
        if (!rst_n)         rem <= '0;
        else if (ovf)       rem <= REM_W'(PULSE_LEN);
        else if (rem != '0) rem <= rem - 1'b1;
    end

    assign rst_req = (rem != '0);

    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> rst_req);
    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> ($past(rem) == REM_W'(1)));
endmodule

// File: rtl/sfr_watchdog.sv
`timescale 1ns/1ps
// Module: sfr_watchdog (top)
// Watchdog peripheral: register decode, prescaler, timeout counter and
// reset-request pulse.
// Assumes: the system routes wdt_rst_req to the other blocks and not back
// into rst_n, so the cause flag keeps its value across the watchdog reset.
module sfr_watchdog
    import wdt_pkg::*;
#(
    parameter int                CNT_W     = 16,
    parameter int                SEL_W     = 3,
    parameter int                BASE_LOG2 = 3,
    parameter int                PULSE_LEN = 4,
    parameter logic [SFR_AW-1:0] CTRL_ADDR = CTRL_ADDR_DEF,
    parameter logic [SFR_AW-1:0] STAT_ADDR = STAT_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [SFR_DW-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [SFR_DW-1:0] sfr_rdata,
    output logic              wdt_rst_req
);
    sfr_wr_t          wr;
    logic             en, clr, tick, ovf;
    logic [SEL_W-1:0] sel;

    assign wr = '{we: sfr_we, addr: sfr_addr, wdata: sfr_wdata};

    wdt_sfr_regs #(
        .SEL_W(SEL_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr), .rd_addr(sfr_addr), .ovf(ovf),
        .en(en), .sel(sel), .clr(clr), .rdata(sfr_rdata)
    );

    wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel),
        .clr(clr || ovf), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .ovf(ovf)
    );

    wdt_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .rst_req(wdt_rst_req)
    );
endmodule

// File: tb/sim_sfr_watchdog.sv
`timescale 1ns/1ps
// Directed bench: each task runs one scenario and checks its own results.
// The counter is narrowed to 6 bits to keep the timeouts short.
module sim_sfr_watchdog;
    localparam int CW    = 6;
    localparam int PLEN  = 4;
    localparam logic [7:0] CTRL = 8'h9F;
    localparam logic [7:0] STAT = 8'hBE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       wdt_rst_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sfr_watchdog #(.CNT_W(CW), .PULSE_LEN(PLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .wdt_rst_req(wdt_rst_req)
    );

    // watchdog of the bench itself
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sfr_we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    function automatic int period(input int s);
        return (1 << CW) * (8 << s);
    endfunction

    // called at the negedge after the starting edge; expects a rise n edges later
    task automatic check_rise(input int n, input string req);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_req) early++;
        end
        chk(early == 0, req, early, 0);
        @(posedge clk); @(negedge clk);
        chk(wdt_rst_req == 1'b1, req, wdt_rst_req, 1);
    endtask

    // called while the pulse is high; counts its length
    task automatic check_pulse_len();
        int hi = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_req) hi++;
            else break;
        end
        chk(hi == PLEN, "R5 pulse length", hi, PLEN);
    endtask

    task automatic watch_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_req) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk(wdt_rst_req == 1'b0, "R1 rst_req", wdt_rst_req, 0);
        sfr_read(CTRL, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        sfr_read(STAT, d); chk(d == 8'h00, "R1 stat", d, 0);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        do_reset();
        sfr_write(CTRL, 8'hFF);
        sfr_read(CTRL, d); chk(d == 8'h87, "R2 ctrl all ones", d, 8'h87);
        sfr_write(CTRL, 8'h03);
        sfr_read(CTRL, d); chk(d == 8'h03, "R2 ctrl sel only", d, 8'h03);
        sfr_read(8'h55, d); chk(d == 8'h00, "R2 other addr", d, 0);
    endtask

    task automatic t_timeout(input int s);
        logic [7:0] d;
        do_reset();
        sfr_write(CTRL, 8'h80 | 8'(s));
        check_rise(period(s), $sformatf("R3 timeout sel=%0d", s));
        check_pulse_len();
        sfr_read(CTRL, d);
        chk(d == 8'(s), "R6 enable dropped, sel kept", d, s);
        sfr_read(STAT, d); chk(d == 8'h01, "R7 flag set", d, 1);
        watch_quiet(1200, "R6 no further pulse");
    endtask

    task automatic t_clear();
        do_reset();
        sfr_write(CTRL, 8'h80);
        repeat (299) @(posedge clk);
        sfr_write(CTRL, 8'hA0);
        check_rise(period(0), "R4 clear restarts period");
    endtask

    task automatic t_hold();
        logic [7:0] d;
        do_reset();
        sfr_write(CTRL, 8'h80);
        repeat (99) @(posedge clk);
        sfr_write(CTRL, 8'h00);
        watch_quiet(600, "R8 quiet while disabled");
        sfr_read(STAT, d); chk(d == 8'h00, "R8 no flag while disabled", d, 0);
        sfr_write(CTRL, 8'h80);
        check_rise(period(0) - 100, "R8 resume from held count");
    endtask

    task automatic t_sel_change();
        do_reset();
        sfr_write(CTRL, 8'h80);
        repeat (255) @(posedge clk);
        sfr_write(CTRL, 8'h81);
        check_rise(512, "R9 select change keeps count");
    endtask

    task automatic t_cause();
        logic [7:0] d;
        do_reset();
        sfr_write(STAT, 8'h01);
        sfr_read(STAT, d); chk(d == 8'h00, "R7 write 1 does not set", d, 0);
        sfr_write(CTRL, 8'h80);
        check_rise(period(0), "R7 overflow for flag");
        sfr_write(STAT, 8'h01);
        sfr_read(STAT, d); chk(d == 8'h01, "R7 write 1 keeps flag", d, 1);
        sfr_write(STAT, 8'h00);
        sfr_read(STAT, d); chk(d == 8'h00, "R7 write 0 clears", d, 0);
        sfr_write(CTRL, 8'h80);
        check_rise(period(0), "R7 second overflow");
        sfr_read(STAT, d); chk(d == 8'h01, "R7 flag set again", d, 1);
        do_reset();
        sfr_read(STAT, d); chk(d == 8'h00, "R7 external reset clears", d, 0);
    endtask

    initial begin
        t_reset();
        t_ctrl_rw();
        t_timeout(0);
        t_timeout(2);
        t_timeout(7);
        t_clear();
        t_hold();
        t_sel_change();
        t_cause();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule